// File: doc/BRIEF.md
# Serial NOR Flash Word-Increment Programmer

This block copies a run of bytes from a host-side buffer into a serial NOR flash. It uses the flash's auto-address-increment word-program mode. The host gives a 24-bit start address and a byte count, then pulses `start`. The block reads the buffer through a byte-wide port whose data returns in the same cycle. It drives a mode-0 SPI master and raises `done` for one cycle when the sequence ends. If the busy poll runs out of time, `error` is raised as well.

Each program step is preceded by a write-enable frame. An odd start address is handled with a single-byte program. Pairs of bytes are then written as word frames. Only the first word frame carries an address; the flash advances it internally. After every program frame the status register is polled until the write-in-progress bit clears. Word mode is left with a write-disable frame. A byte left over at the end gets its own write-enable and byte-program pair.

Top module: `aaiw_top`

## Requirements
- R1: Every byte-program frame (opcode 0x02) and every first word frame is preceded by a one-byte write-enable frame (opcode 0x06) in its own chip-select period.
- R2: For an odd start address, the first program is one byte-program frame: opcode 0x02, the 24-bit address MSB first, then the first buffer byte. Word programming then continues at the next even address.
- R3: The first word frame is 0xAD, then three address bytes, then two data bytes (lower address first). Later word frames are 0xAD plus two data bytes only. The address advances by 2 after every word.
- R4: After each program frame, read-status frames (0x05 plus one dummy byte, status returned in the second byte) are repeated while status bit 0 reads 1. No program frame follows until it reads 0.
- R5: After the last word frame and its poll, one write-disable frame (opcode 0x04) is sent. It is sent only if at least one word frame was sent.
- R6: A single byte left after the words is programmed at the current address by a write-enable frame and a byte-program frame, sent after the write-disable.
- R7: SPI runs in mode 0 (clock idles low, data MSB first, sampled on the rising edge). Chip select stays high for at least one SPI clock period (2*HALF_DIV cycles) between frames, and the clock toggles only while chip select is low.
- R8: If status bit 0 still reads 1 at the end of a poll frame after at least `busy_limit` cycles of polling, the sequence stops with `done` and `error`, and no further frames follow.
- R9: A zero-length request raises `done` in the cycle after `start`, with `error` low and no SPI traffic.
- R10: `done` is a one-cycle pulse per request. `error` stays valid after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a request (accepted when idle) |
| start_addr | input | 24 | Flash address of the first byte |
| byte_len | input | LEN_W | Number of bytes to write |
| busy_limit | input | TO_W | Busy-poll timeout in clock cycles |
| buf_addr | output | LEN_W | Buffer index being read |
| buf_data | input | 8 | Buffer byte at `buf_addr`, same cycle |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, held until next start |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
The bench models the flash at the pin level. It tracks the write-enable and word-mode latches and rejects any program frame that breaks the protocol. It compares a flash image against the buffer and counts frames of each kind. The directed cases are even and odd start addresses combined with even and odd lengths, and lengths of zero and one. These separate the lead-byte, word-loop, write-disable and tail-byte paths, since each combination gives a different frame mix. The busy depth is varied to show that polling repeats exactly while the flash reports busy. A flash that never finishes exposes the timeout path. Seeded random addresses and lengths mix all paths together.

// File: rtl/aaiw_pkg.sv
// Shared types and opcodes for the word-increment flash programmer.
package aaiw_pkg;
    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_BPROG = 8'h02;
    localparam logic [7:0] OP_WORD = 8'hAD;

    typedef enum logic [2:0] {
        F_WREN, F_WRDI, F_RDSR, F_BP, F_AAI1, F_AAIN
    } frame_t;

    typedef enum logic [1:0] {
        ST_LEAD, ST_WORDS, ST_TAIL
    } stage_t;

    // Number of bytes in a frame of the given kind.
    function automatic logic [2:0] frame_len(frame_t f);
        case (f)
            F_WREN, F_WRDI: return 3'd1;
            F_RDSR:         return 3'd2;
            F_BP:           return 3'd5;
            F_AAI1:         return 3'd6;
            default:        return 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/aaiw_spi_byte.sv
// Mode-0 SPI byte shifter. Sends tx MSB first and samples miso on the rising edge.
// Each clock half lasts HALF_DIV cycles. Assumes go arrives only while idle.
module aaiw_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic [7:0] rx,
    output logic       byte_done,
    output logic       sck,
    output logic       mosi
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;

    assign mosi = sh[7];

    // Half-period timer, clock edges, and shift/sample per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; sck <= 1'b0; cnt <= '0; bitn <= '0;
            sh <= '0; rx <= '0; byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1; sh <= tx; cnt <= '0; bitn <= '0;
                end
            end else if (cnt == CNT_W'(HALF_DIV - 1)) begin
                cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck  <= 1'b0;
                    sh   <= {sh[6:0], 1'b0};
                    bitn <= bitn + 3'd1;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
endmodule

// File: rtl/aaiw_frame.sv
// Picks the byte to send for a given frame kind and byte index.
// Also says which of the two data bytes of the frame is being read.
module aaiw_frame
    import aaiw_pkg::*;
(
    input  frame_t            ftype,
    input  logic [2:0]        bidx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic [7:0]        tx,
    output logic              data_hi
);
    // Byte mux per frame layout.
    always_comb begin
        tx = 8'h00;
        data_hi = 1'b0;
        case (ftype)
            F_WREN: tx = OP_WREN;
            F_WRDI: tx = OP_WRDI;
            F_RDSR: tx = (bidx == 3'd0) ? OP_RDSR : 8'h00;
            F_BP, F_AAI1: begin
                case (bidx)
                    3'd0: tx = (ftype == F_BP) ? OP_BPROG : OP_WORD;
                    3'd1: tx = addr[23:16];
                    3'd2: tx = addr[15:8];
                    3'd3: tx = addr[7:0];
                    default: begin
                        tx = data;
                        data_hi = (bidx == 3'd5);
                    end
                endcase
            end
            default: begin
                tx = (bidx == 3'd0) ? OP_WORD : data;
                data_hi = (bidx == 3'd2);
            end
        endcase
    end
endmodule

// File: rtl/aaiw_seq.sv
// Frame sequencer: lead byte, word loop with busy polls, write-disable, tail byte.
// Drives chip select, holds the gap between frames and runs the poll timeout.
// Assumes the shifter pulses byte_done once for each go.
module aaiw_seq
    import aaiw_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TO_W = 20,
    parameter int GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic [TO_W-1:0]   busy_limit,
    input  logic              byte_done,
    input  logic [7:0]        rx,
    input  logic              data_hi,
    output logic              go,
    output frame_t            ftype,
    output logic [2:0]        bidx,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  buf_addr,
    output logic              cs_n,
    output logic              done,
    output logic              err
);
    localparam int GAP_W = $clog2(GAP + 1);
    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

    state_t           state;
    stage_t           stage;
    logic             issued;
    logic [GAP_W-1:0] gap_cnt;
    logic [LEN_W-1:0] didx, remain;
    logic [TO_W-1:0]  poll_cnt;
    logic             fend, is_word;

    assign cs_n     = (state != S_SHIFT);
    assign go       = (state == S_SHIFT) && !issued;
    assign buf_addr = didx + LEN_W'(data_hi);
    assign fend     = (state == S_SHIFT) && byte_done && (bidx == frame_len(ftype) - 3'd1);
    assign is_word  = (ftype == F_AAI1) || (ftype == F_AAIN);

    // Main sequencing: accept start, walk bytes, choose the next frame at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; stage <= ST_LEAD; ftype <= F_WREN; issued <= 1'b0;
            bidx <= '0; gap_cnt <= '0; addr <= '0; didx <= '0; remain <= '0;
            poll_cnt <= '0; done <= 1'b0; err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ftype == F_RDSR && state != S_IDLE && poll_cnt != '1)
                poll_cnt <= poll_cnt + TO_W'(1);
            case (state)
                S_IDLE: if (start) begin
                    err <= 1'b0; addr <= start_addr; didx <= '0; remain <= byte_len;
                    ftype <= F_WREN; bidx <= '0; issued <= 1'b0;
                    if (byte_len == '0) done <= 1'b1;
                    else begin
                        state <= S_SHIFT;
                        if (start_addr[0])            stage <= ST_LEAD;
                        else if (byte_len >= LEN_W'(2)) stage <= ST_WORDS;
                        else                          stage <= ST_TAIL;
                    end
                end
                S_GAP: begin
                    gap_cnt <= gap_cnt + GAP_W'(1);
                    if (gap_cnt == GAP_W'(GAP - 1)) begin
                        state <= S_SHIFT; bidx <= '0; issued <= 1'b0;
                    end
                end
                default: begin
                    if (go) issued <= 1'b1;
                    if (byte_done) begin
                        issued <= 1'b0;
                        bidx <= bidx + 3'd1;
                    end
                    if (fend) begin
                        state <= S_GAP; gap_cnt <= '0;
                        case (ftype)
                            F_WREN: ftype <= (stage == ST_WORDS) ? F_AAI1 : F_BP;
                            F_BP: begin
                                didx <= didx + LEN_W'(1); addr <= addr + ADDR_W'(1);
                                remain <= remain - LEN_W'(1); ftype <= F_RDSR; poll_cnt <= '0;
                            end
                            F_AAI1, F_AAIN: begin
                                didx <= didx + LEN_W'(2); addr <= addr + ADDR_W'(2);
                                remain <= remain - LEN_W'(2); ftype <= F_RDSR; poll_cnt <= '0;
                            end
                            F_WRDI: begin
                                if (remain == LEN_W'(1)) begin
                                    stage <= ST_TAIL; ftype <= F_WREN;
                                end else begin
                                    state <= S_IDLE; done <= 1'b1;
                                end
                            end
                            default: begin
                                if (rx[0]) begin
                                    if (poll_cnt >= busy_limit) begin
                                        state <= S_IDLE; done <= 1'b1; err <= 1'b1;
                                    end
                                end else if (stage == ST_LEAD) begin
                                    if (remain == '0) begin
                                        state <= S_IDLE; done <= 1'b1;
                                    end else begin
                                        stage <= (remain == LEN_W'(1)) ? ST_TAIL : ST_WORDS;
                                        ftype <= F_WREN;
                                    end
                                end else if (stage == ST_WORDS) begin
                                    ftype <= (remain >= LEN_W'(2)) ? F_AAIN : F_WRDI;
                                end else begin
                                    state <= S_IDLE; done <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fend && is_word) |=> (addr == $past(addr) + ADDR_W'(2)));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && byte_len == '0) |=> (done && !err && cs_n));
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
    assert_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/aaiw_top.sv
// Word-increment flash programmer top: sequencer, frame byte mux and SPI shifter.
// Assumes buf_data answers buf_addr in the same cycle.
module aaiw_top
    import aaiw_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int TO_W = 20,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic [TO_W-1:0]   busy_limit,
    output logic [LEN_W-1:0]  buf_addr,
    input  logic [7:0]        buf_data,
    output logic              done,
    output logic              error,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int GAP = 2 * HALF_DIV;

    logic              go, byte_done, data_hi;
    logic [7:0]        tx, rx;
    frame_t            ftype;
    logic [2:0]        bidx;
    logic [ADDR_W-1:0] addr;

    aaiw_seq #(.LEN_W(LEN_W), .TO_W(TO_W), .GAP(GAP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .busy_limit(busy_limit), .byte_done(byte_done),
        .rx(rx), .data_hi(data_hi), .go(go), .ftype(ftype), .bidx(bidx),
        .addr(addr), .buf_addr(buf_addr), .cs_n(spi_cs_n), .done(done), .err(error)
    );

    aaiw_frame u_frame (
        .ftype(ftype), .bidx(bidx), .addr(addr), .data(buf_data),
        .tx(tx), .data_hi(data_hi)
    );

    aaiw_spi_byte #(.HALF_DIV(HALF_DIV)) u_spi (
        .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .miso(spi_miso),
        .rx(rx), .byte_done(byte_done), .sck(spi_sck), .mosi(spi_mosi)
    );

    assert_sck_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
endmodule

// File: tb/sim_aaiw_top.sv
module sim_aaiw_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int MEMSZ = 512;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, spi_miso = 1'b0;
    logic [23:0] start_addr = '0;
    logic [15:0] byte_len = '0, buf_addr;
    logic [19:0] busy_limit = 20'd100000;
    logic [7:0]  buf_data;
    logic        done, error, spi_cs_n, spi_sck, spi_mosi;

    logic [7:0] tbuf [0:31];
    logic [7:0] mem  [0:MEMSZ-1];
    logic [7:0] fb   [0:7];
    int nchk = 0, nfail = 0, cyc = 0;
    int bitc, nb, busy_left, busy_cfg = 0, last_rise, min_gap;
    bit wel, aai, have_prev;
    int n_wren, n_wrdi, n_rdsr, n_bp, n_aai, proto_err, n_frames;
    logic [23:0] aai_addr;
    logic [7:0] shreg;

    assign buf_data = tbuf[buf_addr[4:0]];
    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    aaiw_top u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .busy_limit(busy_limit), .buf_addr(buf_addr),
        .buf_data(buf_data), .done(done), .error(error), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prog(logic [23:0] a, logic [7:0] d);
        if (a < MEMSZ) mem[a] = mem[a] & d; else proto_err++;
    endtask

    // Flash model: shift in on rising sck, status out on falling sck.
    always @(negedge spi_cs_n) begin
        bitc = 0; nb = 0; spi_miso = 1'b0;
        if (have_prev && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        bitc++;
        if (bitc % 8 == 0 && nb < 8) begin fb[nb] = shreg; nb++; end
    end
    always @(negedge spi_sck) if (!spi_cs_n && nb >= 1 && fb[0] == 8'h05 && bitc >= 8 && bitc < 16)
        spi_miso = (15 - bitc == 0) ? (busy_left > 0) : 1'b0;
    always @(posedge spi_cs_n) if (rst_n) begin
        last_rise = cyc; have_prev = 1; n_frames++;
        case (fb[0])
            8'h06: begin wel = 1; n_wren++; end
            8'h04: begin wel = 0; aai = 0; n_wrdi++; end
            8'h05: begin if (busy_left > 0) busy_left--; n_rdsr++; end
            8'h02: begin
                if (!wel || aai || nb != 5 || busy_left != 0) proto_err++;
                prog({fb[1], fb[2], fb[3]}, fb[4]);
                wel = 0; busy_left = busy_cfg; n_bp++;
            end
            8'hAD: begin
                if (busy_left != 0) proto_err++;
                if (!aai) begin
                    if (!wel || nb != 6 || fb[3][0]) proto_err++;
                    aai = 1; aai_addr = {fb[1], fb[2], fb[3]};
                    prog(aai_addr, fb[4]); prog(aai_addr + 1, fb[5]);
                end else begin
                    if (nb != 3) proto_err++;
                    prog(aai_addr, fb[1]); prog(aai_addr + 1, fb[2]);
                end
                aai_addr += 2; busy_left = busy_cfg; n_aai++;
            end
            default: proto_err++;
        endcase
    end

    task automatic model_reset();
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hFF;
        wel = 0; aai = 0; busy_left = 0; have_prev = 0; min_gap = 1000000;
        n_wren = 0; n_wrdi = 0; n_rdsr = 0; n_bp = 0; n_aai = 0; proto_err = 0; n_frames = 0;
    endtask

    // Runs one request and checks image, frame mix, gaps and done/error.
    task automatic run_op(int a, int len, int bcfg, string tag);
        int lead, rem, words, tail, ndone, waitc;
        bit ok;
        model_reset();
        busy_cfg = bcfg;
        for (int i = 0; i < 32; i++) tbuf[i] = 8'($urandom);
        @(negedge clk);
        start_addr = 24'(a); byte_len = 16'(len); start = 1'b1;
        @(negedge clk); start = 1'b0;
        ndone = 0; waitc = 0;
        if (done) ndone++;
        while (ndone == 0 && waitc < 20000) begin
            @(negedge clk); waitc++;
            if (done) ndone++;
        end
        check(ndone == 1, "R10 watchdog/done", ndone, 1);
        check(error == 1'b0, "R10 error low", int'(error), 0);
        @(negedge clk);
        check(!done, "R10 done pulse", int'(done), 0);
        lead = (a % 2 == 1 && len > 0) ? 1 : 0;
        rem = len - lead; words = rem / 2; tail = rem % 2;
        ok = 1;
        for (int i = 0; i < MEMSZ; i++)
            if (mem[i] != ((i >= a && i < a + len) ? tbuf[i - a] : 8'hFF)) ok = 0;
        check(ok, {"R2 R3 R6 image ", tag}, int'(ok), 1);
        check(proto_err == 0, {"R1 R4 protocol ", tag}, proto_err, 0);
        check(n_wren == lead + (words > 0 ? 1 : 0) + tail, {"R1 wren count ", tag}, n_wren,
              lead + (words > 0 ? 1 : 0) + tail);
        check(n_bp == lead + tail, {"R6 byte frames ", tag}, n_bp, lead + tail);
        check(n_aai == words, {"R3 word frames ", tag}, n_aai, words);
        check(n_wrdi == (words > 0 ? 1 : 0), {"R5 wrdi ", tag}, n_wrdi, words > 0 ? 1 : 0);
        check(n_rdsr == (lead + tail + words) * (bcfg + 1), {"R4 polls ", tag}, n_rdsr,
              (lead + tail + words) * (bcfg + 1));
        if (n_frames > 1) check(min_gap >= 2 * HALF, "R7 cs gap", min_gap, 2 * HALF);
    endtask

    initial begin
        int seed, t0;
        seed = $urandom(32'd4242);
        model_reset();
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R7 reset idle", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !error, "R10 reset flags", int'(done), 0);

        // R9 zero length
        model_reset();
        start_addr = 24'd3; byte_len = '0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done && !error, "R9 zero len done", int'(done), 1);
        repeat (20) @(negedge clk);
        check(n_frames == 0 && spi_cs_n, "R9 no traffic", n_frames, 0);

        run_op(16, 6, 0, "even/even");
        run_op(33, 5, 1, "odd/odd");
        run_op(41, 4, 2, "odd/even");
        run_op(64, 1, 0, "even/1");
        run_op(75, 1, 1, "odd/1");
        run_op(100, 3, 3, "even/odd");
        run_op(201, 2, 0, "odd/2");
        for (int k = 0; k < 10; k++)
            run_op(int'($urandom % 400), int'($urandom % 21), int'($urandom % 3), "random");

        // R8 timeout: flash stays busy
        model_reset();
        busy_cfg = 100000; busy_limit = 20'd60;
        for (int i = 0; i < 32; i++) tbuf[i] = 8'(i);
        start_addr = 24'd8; byte_len = 16'd6; start = 1'b1;
        @(negedge clk); start = 1'b0;
        t0 = 0;
        while (!done && t0 < 20000) begin @(negedge clk); t0++; end
        check(done && error, "R8 timeout error", int'(error), 1);
        t0 = n_frames;
        repeat (300) @(negedge clk);
        check(n_frames == t0 && spi_cs_n, "R8 no frames after", n_frames, t0);
        check(n_aai == 1 && n_wrdi == 0, "R8 stop after first word", n_aai, 1);
        check(error == 1'b1, "R10 error held", int'(error), 1);
        busy_limit = 20'd100000;
        run_op(130, 4, 0, "after timeout");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule